// File: doc/BRIEF.md
# Tachometer Pulse Mask and Divider

This block sits between a motor tachometer input and a timer or capture unit. It brings the raw pulse train into the clock domain and finds its edges. A programmable noise window then discards edges that follow an accepted edge too closely. The accepted edges are divided down to one single-cycle output pulse per group of N.

Two 8-bit read/write registers set it up over a small register bus. The divide register selects the ratio, and its zero value also switches the block to detect both edges. The mask register sets the length of the noise window in ticks of a mask clock. An external select bit picks the mask clock from two prescaler rates, and the register bus has no access to that bit.

Top module: `tach_conditioner`

## Requirements
- R1: After reset the divide register and the mask register both read 0x00, and `tach_pulse` is low.
- R2: A write with `reg_wr` high stores `reg_wdata` in the divide register at address 0x50 or in the mask register at address 0x51. `reg_rdata` returns the addressed register combinationally and returns 0x00 for any other address.
- R3: `tach_in` passes through two synchronising flops and one history flop. An input change driven before clock edge k gives its output pulse in the cycle that follows edge k+2.
- R4: With the divide register at 0x00, every rising and every falling edge that is not masked gives one output pulse.
- R5: With the divide register at N from 1 to 255, only rising edges count and falling edges are ignored. One pulse is emitted on every N-th accepted rising edge.
- R6: Each output pulse lasts exactly one clock cycle.
- R7: An accepted edge loads a mask countdown with the mask register value. While the countdown is non-zero, detected edges are discarded and do not reload it. The countdown falls by one on each mask tick.
- R8: With the mask register at 0x00, no edge is ever discarded.
- R9: The mask tick comes from a free-running prescaler that starts at zero when reset is released. With `mclk_sel`=0 it fires on the cycles where the count of cycles since release, taken modulo 2, equals 1. With `mclk_sel`=1 it fires where the count modulo 8 equals 7. The countdown changes only on a tick or on an accepted edge.
- R10: A write to the divide register clears the divide progress, so the next pulse comes after exactly N new accepted edges. An edge accepted in the same cycle as that write gives no pulse and is not counted.
- R11: Masking is applied before division, so discarded edges never advance the divide count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | 1 | Raw asynchronous tachometer input |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| mclk_sel | input | 1 | Mask clock select: 0 = fast tick, 1 = slow tick |
| tach_pulse | output | 1 | Conditioned single-cycle output pulse |

## Verification
The bench aims at the coincidence of a divide-register write with an accepted edge. A design that let the edge through would give an early pulse. The bench drives bursts of edges inside the mask window. A design that divided before masking, or that let discarded edges reload the window, would give a different pulse count from the reference model. The mask tick phase is checked against both select settings, where a prescaler off by one cycle would move the end of a window. Falling edges are driven under a non-zero ratio, and a design that counted them would pulse at twice the rate.

// File: rtl/tach_conditioner.sv
module tach_conditioner #(
  parameter int         FAST_DIV  = 2,
  parameter int         SLOW_DIV  = 8,
  parameter logic [7:0] DIV_ADDR  = 8'h50,
  parameter logic [7:0] MASK_ADDR = 8'h51
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tach_in,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       mclk_sel,
  output logic       tach_pulse
);
  localparam int PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [7:0]    div_q, mask_q, mcnt_q, dcnt_q;
  logic [2:0]    sync_q;
  logic [PW-1:0] pre_q;
  logic          pulse_q;

  wire wr_div  = reg_wr && (reg_addr == DIV_ADDR);
  wire wr_mask = reg_wr && (reg_addr == MASK_ADDR);

  wire pre_wrap = (pre_q == PW'(SLOW_DIV - 1));
  wire tick     = mclk_sel ? pre_wrap
                           : ((pre_q % PW'(FAST_DIV)) == PW'(FAST_DIV - 1));

  wire edge_det = (div_q == 8'd0) ? (sync_q[1] ^ sync_q[2])
                                  : (sync_q[1] & ~sync_q[2]);
  wire accept   = edge_det && (mcnt_q == 8'd0);
  wire div_hit  = (dcnt_q == div_q - 8'd1);

  assign reg_rdata  = (reg_addr == DIV_ADDR)  ? div_q  :
                      (reg_addr == MASK_ADDR) ? mask_q : 8'h00;
  assign tach_pulse = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= 8'h00;
      mask_q <= 8'h00;
    end else begin
      if (wr_div)  div_q  <= reg_wdata;
      if (wr_mask) mask_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 3'b000;
      pre_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], tach_in};
      pre_q  <= pre_wrap ? '0 : pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mcnt_q <= 8'h00;
    else if (accept)
      mcnt_q <= mask_q;
    else if (tick && mcnt_q != 8'd0)
      mcnt_q <= mcnt_q - 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q  <= 8'h00;
      pulse_q <= 1'b0;
    end else if (wr_div) begin
      dcnt_q  <= 8'h00;
      pulse_q <= 1'b0;
    end else if (accept) begin
      if (div_q == 8'd0) begin
        pulse_q <= 1'b1;
      end else if (div_hit) begin
        dcnt_q  <= 8'h00;
        pulse_q <= 1'b1;
      end else begin
        dcnt_q  <= dcnt_q + 8'd1;
        pulse_q <= 1'b0;
      end
    end else begin
      pulse_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tach_conditioner_chk.sv
module tach_conditioner_chk #(
  parameter logic [7:0] DIV_ADDR = 8'h50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tach_pulse,
  input logic       reg_wr,
  input logic [7:0] reg_addr,
  input logic [7:0] div_q,
  input logic [7:0] mask_q,
  input logic [7:0] mcnt_q,
  input logic [7:0] dcnt_q,
  input logic [2:0] sync_q,
  input logic       tick,
  input logic       edge_det,
  input logic       accept
);
  wire wr_div = reg_wr && (reg_addr == DIV_ADDR);

  assert_masked_edge_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_det && mcnt_q != 8'd0) |=> !tach_pulse);

  assert_mask_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mcnt_q == $past(mask_q)));

  assert_mask_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !tick) |=> $stable(mcnt_q));

  assert_div_write_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div |=> (dcnt_q == 8'd0 && !tach_pulse));

  assert_falling_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != 8'd0 && !sync_q[1] && sync_q[2]) |=> !tach_pulse);

  assert_div_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != 8'd0) |-> (dcnt_q < div_q));

  assert_both_edges_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == 8'd0 && mcnt_q == 8'd0 && edge_det && !wr_div) |=> tach_pulse);
endmodule

bind tach_conditioner tach_conditioner_chk #(.DIV_ADDR(DIV_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .tach_pulse(tach_pulse), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .div_q(div_q), .mask_q(mask_q), .mcnt_q(mcnt_q),
  .dcnt_q(dcnt_q), .sync_q(sync_q), .tick(tick), .edge_det(edge_det),
  .accept(accept)
);

// File: tb/tach_conditioner_bench.sv
`timescale 1ns/1ps
module tach_conditioner_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tin = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       sel = 1'b0;
  logic [7:0] rdata;
  logic       pulse;

  int    total = 0, bad = 0, pcount = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  tach_conditioner u_tach_conditioner (
    .clk(clk), .rst_n(rst_n), .tach_in(tin), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .mclk_sel(sel), .tach_pulse(pulse)
  );

  // behavioural reference
  int smp[$] = '{0, 0, 0};
  int mdiv = 0, mmask = 0, mrem = 0, mprog = 0, cyc = 0;
  bit exp_pulse = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      smp = '{0, 0, 0};
      mdiv = 0; mmask = 0; mrem = 0; mprog = 0; cyc = 0; exp_pulse = 0;
    end else begin
      int  cur, prv, per;
      bit  det, acc, tk;
      cur = smp[1];
      prv = smp[0];
      det = (mdiv == 0) ? (cur != prv) : (cur == 1 && prv == 0);
      acc = det && (mrem == 0);
      per = sel ? 8 : 2;
      tk  = (cyc % per) == per - 1;
      if (acc) mrem = mmask;
      else if (tk && mrem > 0) mrem = mrem - 1;
      exp_pulse = 0;
      if (wr && addr == 8'h50) mprog = 0;
      else if (acc) begin
        if (mdiv == 0) exp_pulse = 1;
        else begin
          mprog = mprog + 1;
          if (mprog == mdiv) begin mprog = 0; exp_pulse = 1; end
        end
      end
      if (wr && addr == 8'h50) mdiv = wdata;
      if (wr && addr == 8'h51) mmask = wdata;
      smp.push_back(int'(tin));
      void'(smp.pop_front());
      cyc = cyc + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      total = total + 1;
      if (pulse !== exp_pulse) begin
        bad = bad + 1;
        $display("FAIL %s: tach_pulse=%0b expected %0b at t=%0t", cur_req, pulse, exp_pulse, $time);
      end
      if (pulse === 1'b1) pcount = pcount + 1;
    end
  end

  task automatic check(string req, int act, int expv);
    total = total + 1;
    if (act != expv) begin
      bad = bad + 1;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(logic [7:0] a, logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_check(logic [7:0] a, int expv, string req);
    addr = a;
    #1;
    check(req, int'(rdata), expv);
  endtask

  task automatic toggles(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tin = ~tin;
      cycles(gap);
    end
  endtask

  initial begin
    int base, fastn, slown;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    cur_req = "R1";
    rd_check(8'h50, 0, "R1");
    rd_check(8'h51, 0, "R1");
    check("R1", int'(pulse), 0);

    // R2 register access
    cur_req = "R2";
    wreg(8'h50, 8'h03);
    wreg(8'h51, 8'h05);
    rd_check(8'h50, 3, "R2");
    rd_check(8'h51, 5, "R2");
    rd_check(8'h52, 0, "R2");
    wreg(8'h50, 8'h00);
    wreg(8'h51, 8'h00);
    cycles(4);

    // R3 latency and R6 width
    cur_req = "R3";
    tin = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R3", int'(pulse), 0);
    @(negedge clk);
    check("R3", int'(pulse), 1);
    @(negedge clk);
    check("R6", int'(pulse), 0);
    cycles(4);

    // R4 both edges with no division
    cur_req = "R4";
    base = pcount;
    toggles(7, 4);
    cycles(4);
    check("R4", pcount - base, 7);

    // R5 divide by 3, rising only
    cur_req = "R5";
    wreg(8'h50, 8'd3);
    base = pcount;
    toggles(18, 4);
    cycles(4);
    check("R5", pcount - base, 3);

    // R8 zero mask, rapid edges
    cur_req = "R8";
    wreg(8'h50, 8'd1);
    base = pcount;
    toggles(16, 1);
    cycles(4);
    check("R8", pcount - base, 8);

    // R7 / R9 masking at both tick rates
    cur_req = "R7";
    wreg(8'h51, 8'd3);
    sel = 1'b0;
    base = pcount;
    toggles(8, 20);
    check("R7", pcount - base, 4);
    base = pcount;
    toggles(20, 2);
    cycles(40);
    fastn = pcount - base;
    check("R7", int'(fastn < 10), 1);
    cur_req = "R9";
    sel = 1'b1;
    base = pcount;
    toggles(20, 2);
    cycles(40);
    slown = pcount - base;
    check("R9", int'(slown <= 3), 1);
    check("R9", int'(fastn > slown), 1);

    // R10 divide write clears progress, and wins over a coincident edge
    cur_req = "R10";
    sel = 1'b0;
    wreg(8'h51, 8'd0);
    wreg(8'h50, 8'd4);
    base = pcount;
    toggles(4, 4);
    wreg(8'h50, 8'd4);
    toggles(6, 4);
    cycles(4);
    check("R10", pcount - base, 0);
    toggles(2, 4);
    cycles(4);
    check("R10", pcount - base, 1);
    base = pcount;
    tin = ~tin;
    cycles(2);
    wreg(8'h50, 8'd1);
    cycles(4);
    check("R10", pcount - base, 0);
    tin = ~tin;
    cycles(8);

    // R11 masked edges do not advance the divider
    cur_req = "R11";
    wreg(8'h51, 8'd5);
    wreg(8'h50, 8'd2);
    tin = 1'b0;
    cycles(30);
    base = pcount;
    tin = 1'b1; cycles(2);
    tin = 1'b0; cycles(2);
    tin = 1'b1; cycles(2);
    tin = 1'b0; cycles(8);
    check("R11", pcount - base, 0);
    cycles(40);
    tin = 1'b1; cycles(6);
    check("R11", pcount - base, 1);

    // mixed random stimulus against the reference model
    cur_req = "R7/R9/R11";
    for (int k = 0; k < 40; k++) begin
      wreg(8'h50, 8'($urandom_range(0, 4)));
      wreg(8'h51, 8'($urandom_range(0, 6)));
      sel = 1'($urandom_range(0, 1));
      for (int j = 0; j < 40; j++) begin
        if ($urandom_range(0, 3) == 0) tin = ~tin;
        cycles(1);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule